// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block performs the integer multiply and divide operations of a 32-bit processor, one bit per clock. The pipeline pulses `start` with an operation code and two operands. The unit raises `busy` for the whole operation so the pipeline can hold its later instructions. When the operation finishes, `busy` drops and `done` pulses for one cycle with the 64-bit result on `result`.

Signed multiplication uses radix-2 Booth recoding. Each step looks at the current and the previous multiplier bit and then adds, subtracts or skips the multiplicand before an arithmetic shift. Unsigned multiplication uses a plain shift-and-add step. Both kinds of division run a restoring divider on the operand magnitudes. A final extra cycle corrects the signs and handles the special cases.

For a divide, the quotient sits in the lower half of `result` and the remainder in the upper half. The operand width is a parameter `W` with a default of 32. A multiply takes `W` cycles and a divide takes `W+1` cycles.

Top module: `muldiv_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `busy`, `done` and `result` are all zero.
- R2: A `start` pulse while `busy` is low accepts the operation: `busy` is high in the cycle after the accepting edge.
- R3: Operation code 2'b00 (signed multiply) yields the full 2W-bit two's-complement product of the signed operands on `result`.
- R4: Operation code 2'b01 (unsigned multiply) yields the full 2W-bit product of the operands taken as unsigned.
- R5: A multiply keeps `busy` high for exactly W cycles. In the cycle `busy` falls, `done` is high for that one cycle only.
- R6: Operation code 2'b10 (signed divide) puts the quotient, truncated toward zero, in `result[W-1:0]`. It puts the remainder, which carries the sign of the dividend, in `result[2W-1:W]`.
- R7: Operation code 2'b11 (unsigned divide) puts the unsigned quotient in `result[W-1:0]` and the remainder in `result[2W-1:W]`.
- R8: A divide keeps `busy` high for exactly W+1 cycles, then pulses `done` for one cycle.
- R9: Dividing by zero, in either signedness, gives a quotient of all ones and a remainder equal to the dividend.
- R10: A signed divide of the most negative value by -1 gives that most negative value as quotient and zero as remainder.
- R11: A `start` pulse while `busy` is high is ignored: the operation in flight keeps its latency and its result.
- R12: `result` keeps its value after `done` until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse to begin an operation |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opnd_a | input | W | Multiplier or dividend |
| opnd_b | input | W | Multiplicand or divisor |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | 2W | Product, or {remainder, quotient} |

## Verification
The embedded properties check the handshake on every cycle. An idle start always raises busy. Done appears only as a single cycle right after busy falls. The step counter never passes the divide length. The captured operation code cannot change while busy. The result register moves only when done rises. The numeric correctness of the Booth, shift-add and restoring datapaths cannot be shown by these properties. It is shown by the bench's exhaustive sweep of every operand pair at a 4-bit width for all four operation codes. That sweep is compared with arithmetic operators and also covers the exact latencies, division by zero, signed overflow and a start issued mid-operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;

endpackage

// File: rtl/md_booth_step.sv
// One radix-2 Booth step: add/subtract multiplicand by the recoded
// bit pair, then arithmetic shift of {hi, lo, previous bit}.
module md_booth_step #(
    parameter int W = 32
) (
    input  logic [W:0]   hi_i,
    input  logic [W-1:0] lo_i,
    input  logic         qprev_i,
    input  logic [W-1:0] mcand_i,
    output logic [W:0]   hi_o,
    output logic [W-1:0] lo_o,
    output logic         qprev_o
);
    logic [W:0] mext;
    logic [W:0] sum;

    always_comb begin
        mext = {mcand_i[W-1], mcand_i};
        case ({lo_i[0], qprev_i})
            2'b01:   sum = hi_i + mext;
            2'b10:   sum = hi_i - mext;
            default: sum = hi_i;
        endcase
        hi_o    = {sum[W], sum[W:1]};
        lo_o    = {sum[0], lo_i[W-1:1]};
        qprev_o = lo_i[0];
    end
endmodule

// File: rtl/md_shadd_step.sv
// One unsigned shift-and-add step.
module md_shadd_step #(
    parameter int W = 32
) (
    input  logic [W:0]   hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] mcand_i,
    output logic [W:0]   hi_o,
    output logic [W-1:0] lo_o
);
    logic [W:0] sum;

    always_comb begin
        sum  = hi_i + (lo_i[0] ? {1'b0, mcand_i} : '0);
        hi_o = {1'b0, sum[W:1]};
        lo_o = {sum[0], lo_i[W-1:1]};
    end
endmodule

// File: rtl/md_rdiv_step.sv
// One restoring-division step on unsigned magnitudes.
module md_rdiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        trial   = shifted - {1'b0, dvs_i};
        if (!trial[W]) begin
            rem_o = trial[W-1:0];
            quo_o = {quo_i[W-2:0], 1'b1};
        end else begin
            rem_o = shifted[W-1:0];
            quo_o = {quo_i[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    output logic             busy,
    output logic             done,
    output logic [2*W-1:0]   result
);
    localparam int CW = $clog2(W + 1) + 1;
    localparam logic [CW-1:0] MUL_LAST = CW'(W - 1);
    localparam logic [CW-1:0] DIV_LAST = CW'(W);

    typedef struct packed {
        logic           busy;
        logic           done;
        md_op_e         op;
        logic [CW-1:0]  cnt;
        logic [W:0]     hi;
        logic [W-1:0]   lo;
        logic           qprev;
        logic [W-1:0]   mval;
        logic [W-1:0]   dvd;
        logic           neg_q;
        logic           neg_r;
        logic [2*W-1:0] res;
    } md_state_t;

    md_state_t st_d, st_q;

    logic [W:0]   bo_hi, sa_hi;
    logic [W-1:0] bo_lo, sa_lo, dv_rem, dv_quo;
    logic         bo_qprev;

    md_booth_step #(.W(W)) i_booth (
        .hi_i(st_q.hi), .lo_i(st_q.lo), .qprev_i(st_q.qprev), .mcand_i(st_q.mval),
        .hi_o(bo_hi), .lo_o(bo_lo), .qprev_o(bo_qprev)
    );

    md_shadd_step #(.W(W)) i_shadd (
        .hi_i(st_q.hi), .lo_i(st_q.lo), .mcand_i(st_q.mval),
        .hi_o(sa_hi), .lo_o(sa_lo)
    );

    md_rdiv_step #(.W(W)) i_rdiv (
        .rem_i(st_q.hi[W-1:0]), .quo_i(st_q.lo), .dvs_i(st_q.mval),
        .rem_o(dv_rem), .quo_o(dv_quo)
    );

    always_comb begin
        logic         sgn;
        logic [W-1:0] qfix, rfix;
        st_d      = st_q;
        st_d.done = 1'b0;
        sgn       = 1'b0;
        qfix      = '0;
        rfix      = '0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.op    = md_op_e'(op);
                st_d.cnt   = '0;
                st_d.hi    = '0;
                st_d.qprev = 1'b0;
                st_d.dvd   = opnd_a;
                sgn        = (md_op_e'(op) == OP_DIVS);
                st_d.neg_q = sgn && (opnd_a[W-1] ^ opnd_b[W-1]);
                st_d.neg_r = sgn && opnd_a[W-1];
                st_d.lo    = (sgn && opnd_a[W-1]) ? -opnd_a : opnd_a;
                st_d.mval  = (sgn && opnd_b[W-1]) ? -opnd_b : opnd_b;
            end
        end else begin
            case (st_q.op)
                OP_MULS, OP_MULU: begin
                    if (st_q.op == OP_MULS) begin
                        st_d.hi    = bo_hi;
                        st_d.lo    = bo_lo;
                        st_d.qprev = bo_qprev;
                    end else begin
                        st_d.hi    = sa_hi;
                        st_d.lo    = sa_lo;
                    end
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == MUL_LAST) begin
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                        st_d.res  = {st_d.hi[W-1:0], st_d.lo};
                    end
                end
                default: begin
                    if (st_q.cnt != DIV_LAST) begin
                        st_d.hi  = {1'b0, dv_rem};
                        st_d.lo  = dv_quo;
                        st_d.cnt = st_q.cnt + 1'b1;
                    end else begin
                        qfix      = st_q.neg_q ? -st_q.lo : st_q.lo;
                        rfix      = st_q.neg_r ? -st_q.hi[W-1:0] : st_q.hi[W-1:0];
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                        if (st_q.mval == '0)
                            st_d.res = {st_q.dvd, {W{1'b1}}};
                        else
                            st_d.res = {rfix, qfix};
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.res;

    a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.cnt <= DIV_LAST));
    a_r11_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (st_q.op == $past(st_q.op)));
    a_r12_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [1:0]     op = '0;
    logic [W-1:0]   opnd_a = '0, opnd_b = '0;
    logic           busy, done;
    logic [2*W-1:0] result;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    muldiv_unit #(.W(W)) i_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] model(input logic [1:0] o, input logic [W-1:0] a, b);
        logic signed [63:0] sa, sb, p, q, r;
        sa = a[W-1] ? $signed({{(64-W){1'b1}}, a}) : $signed({{(64-W){1'b0}}, a});
        sb = b[W-1] ? $signed({{(64-W){1'b1}}, b}) : $signed({{(64-W){1'b0}}, b});
        case (o)
            2'b00: begin p = sa * sb; return p[2*W-1:0]; end
            2'b01: begin p = $signed({{(64-W){1'b0}}, a}) * $signed({{(64-W){1'b0}}, b});
                         return p[2*W-1:0]; end
            2'b10: begin
                if (b == '0) return {a, {W{1'b1}}};
                q = sa / sb; r = sa % sb;
                return {r[W-1:0], q[W-1:0]};
            end
            default: begin
                if (b == '0) return {a, {W{1'b1}}};
                return {a % b, a / b};
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] o, input logic [W-1:0] a, b);
        if (o == 2'b00) return "R3";
        if (o == 2'b01) return "R4";
        if (b == '0) return "R9";
        if (o == 2'b11) return "R7";
        if (a == {1'b1, {(W-1){1'b0}}} && b == {W{1'b1}}) return "R10";
        return "R6";
    endfunction

    task automatic run_op(input logic [1:0] o, input logic [W-1:0] a, b, input bit poke);
        int lat;
        logic [2*W-1:0] held;
        @(negedge clk);
        start = 1'b1; op = o; opnd_a = a; opnd_b = b;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", 64'(busy), 64'd1);
        lat = 0;
        while (busy && lat < 100) begin
            lat++;
            if (poke && lat == 2) begin
                start = 1'b1; op = ~o; opnd_a = ~a; opnd_b = b + 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (o[1]) chk("R8 divide latency", 64'(lat), 64'(W + 1));
        else      chk("R5 multiply latency", 64'(lat), 64'(W));
        chk(poke ? "R11 result after ignored start" : tag_of(o, a, b),
            64'(result), 64'(model(o, a, b)));
        chk("R5 done with busy low", 64'(done), 64'd1);
        held = result;
        @(negedge clk);
        chk("R5 done single cycle", 64'(done), 64'd0);
        chk("R12 result held", 64'(result), 64'(held));
    endtask

    initial begin
        #1;
        chk("R1 busy in reset", 64'(busy), 64'd0);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 result in reset", 64'(result), 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R1 result after reset", 64'(result), 64'd0);
        // R3 R4 R6 R7 R9 R10: exhaustive sweep at 4-bit width
        for (int o = 0; o < 4; o++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    run_op(2'(o), W'(a), W'(b), 1'b0);
        // R11: start issued mid-operation must be ignored
        for (int o = 0; o < 4; o++) begin
            run_op(2'(o), 4'd11, 4'd6, 1'b1);
            run_op(2'(o), 4'd8, 4'd15, 1'b1);
        end
        // R12: result stays after several idle cycles
        run_op(2'b01, 4'd13, 4'd14, 1'b0);
        repeat (5) @(negedge clk);
        chk("R12 result held idle", 64'(result), 64'(model(2'b01, 4'd13, 4'd14)));
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule